// File: doc/BRIEF.md
# Stereo Composite Multiplex Generator

This block turns two signed digital audio channels into a sampled FM-stereo composite baseband signal, one 8-bit offset-binary code per 304 kHz sample tick. On every tick it forms the sum and difference of the channels. It multiplies the difference by a 38 kHz subcarrier, built from an 8-step table. The subcarrier takes no part as a term of its own, so the carrier is suppressed. A 19 kHz pilot from a 16-step table is added last. Both tables are walked by one shared phase counter, so the pilot runs at exactly half the subcarrier rate and stays phase-locked to it.

A mono select removes both the difference term and the pilot. A mute input removes the audio. In stereo mode the pilot keeps running during mute, so a receiver keeps its stereo indication. The composite word leaves through a valid/ready port. The sample rate is fixed by the tick, so back-pressure cannot slow the generator. A word that has not been taken stays on the port until it is accepted, or until the next tick replaces it.

Top module: `stereo_mpx`

## Requirements
- R1: After reset, `comp_code` is 0x80, `comp_valid` is 0 and the phase counter is 0, so the first tick uses phase 0.
- R2: On a clock edge with `tick` high, the inputs present at that edge and the current phase produce a new `comp_code`, and `comp_valid` is 1 from that edge onward.
- R3: The phase counter advances by one on every tick, wrapping modulo 16. The subcarrier index is the phase modulo 8 and the pilot index is the full phase.
- R4: The subcarrier values in Q7 for indices 0..7 are 0, 91, 128, 91, 0, -91, -128, -91. With `SQUARE_SUB`=1 they are +128 for indices 0..3 and -128 for indices 4..7.
- R5: The pilot values for indices 0..7 are 0, 7, 13, 18, 19, 18, 13, 7, and indices 8..15 carry the same values negated. 19 is about 15 % of 127.
- R6: In stereo mode, let m = floor((L+R)/2^(AW-7)), s = floor((L-R)/2^(AW-7)) and a = floor((128·m + s·sub)·AUD_GAIN / 2^14), with AUD_GAIN defaulting to 109 (about 85 %). The code is then 128 + a + pilot.
- R7: With `mono` high, s is 0 and the pilot is 0, so the code carries only the scaled sum.
- R8: With `mute` high, a is 0. In stereo mode the code is 128 + pilot, and in mono mode it is 0x80.
- R9: A result below 0 gives 0x00 and a result above 255 gives 0xFF; values never wrap.
- R10: While `comp_valid` is high and `comp_ready` is low, the word and the valid flag hold. An acceptance with no tick clears `comp_valid`. A tick loads a new word even if the previous word was not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle 304 kHz sample enable |
| left_s | input | AW | Left audio sample, signed |
| right_s | input | AW | Right audio sample, signed |
| mono | input | 1 | 1 selects mono: sum only, pilot off |
| mute | input | 1 | 1 removes the audio contribution |
| comp_ready | input | 1 | Consumer accepts the composite word |
| comp_valid | output | 1 | Composite word available |
| comp_code | output | 8 | Composite code, offset binary (0x80 means zero) |

## Verification
The properties assume that `tick` and the audio and control inputs are known after reset and change only between clock edges. They also assume that `comp_ready` is driven throughout, because the hold and drain rules judge each edge from that pin. The stimulus changes every input at the falling edge, raises `tick` for exactly one cycle at a time and keeps `comp_ready` steady except in the back-pressure sequences. The fixed-value properties tie mono with mute, and mono with silent input, to the zero code, so that result holds for any phase.

// File: rtl/stereo_mpx_pkg.sv
package stereo_mpx_pkg;

  typedef logic signed [8:0] sub_t;
  typedef logic signed [7:0] pil_t;

  localparam int PH_W = 4;

  function automatic sub_t sub_sine(input logic [2:0] idx);
    case (idx)
      3'd0:    return 9'sd0;
      3'd1:    return 9'sd91;
      3'd2:    return 9'sd128;
      3'd3:    return 9'sd91;
      3'd4:    return 9'sd0;
      3'd5:    return -9'sd91;
      3'd6:    return -9'sd128;
      default: return -9'sd91;
    endcase
  endfunction

  function automatic sub_t sub_square(input logic [2:0] idx);
    return idx[2] ? -9'sd128 : 9'sd128;
  endfunction

  function automatic pil_t pilot_val(input logic [3:0] idx);
    pil_t mag;
    case (idx[2:0])
      3'd0:    mag = 8'sd0;
      3'd1:    mag = 8'sd7;
      3'd2:    mag = 8'sd13;
      3'd3:    mag = 8'sd18;
      3'd4:    mag = 8'sd19;
      3'd5:    mag = 8'sd18;
      3'd6:    mag = 8'sd13;
      default: mag = 8'sd7;
    endcase
    return idx[3] ? -mag : mag;
  endfunction

endpackage

// File: rtl/stereo_mpx_phase.sv
module stereo_mpx_phase
  import stereo_mpx_pkg::*;
#(
  parameter bit SQUARE_SUB = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  output sub_t sub_w,
  output pil_t pil_w
);
  logic [PH_W-1:0] phase_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    phase_q <= '0;
    else if (tick) phase_q <= phase_q + 1'b1;
  end

  generate
    if (SQUARE_SUB) begin : g_square
      assign sub_w = sub_square(phase_q[2:0]);
    end else begin : g_sine
      assign sub_w = sub_sine(phase_q[2:0]);
    end
  endgenerate

  assign pil_w = pilot_val(phase_q);
endmodule

// File: rtl/stereo_mpx_mix.sv
module stereo_mpx_mix
  import stereo_mpx_pkg::*;
#(
  parameter int AW       = 16,
  parameter int AUD_GAIN = 109
) (
  input  logic signed [AW-1:0] left_s,
  input  logic signed [AW-1:0] right_s,
  input  logic                 mono,
  input  logic                 mute,
  input  sub_t                 sub_w,
  input  pil_t                 pil_w,
  output logic [7:0]           code
);
  localparam int SH = AW - 7;
  localparam logic signed [27:0] GAIN = 28'(AUD_GAIN);

  logic signed [AW:0]  sum_w, dif_w, sum_sh, dif_sh;
  logic signed [7:0]   mid8, side8;
  logic signed [19:0]  mid_x, side_x, sub_x, acc;
  logic signed [27:0]  scaled;
  logic signed [15:0]  aud, pil, total;

  always_comb begin
    sum_w  = {left_s[AW-1], left_s} + {right_s[AW-1], right_s};
    dif_w  = {left_s[AW-1], left_s} - {right_s[AW-1], right_s};
    sum_sh = sum_w >>> SH;
    dif_sh = dif_w >>> SH;
    mid8   = sum_sh[7:0];
    side8  = mono ? 8'sd0 : dif_sh[7:0];
    mid_x  = 20'(mid8);
    side_x = 20'(side8);
    sub_x  = 20'(sub_w);
    acc    = (mid_x <<< 7) + side_x * sub_x;
    scaled = (28'(acc) * GAIN) >>> 14;
    aud    = mute ? 16'sd0 : scaled[15:0];
    pil    = mono ? 16'sd0 : 16'(pil_w);
    total  = 16'sd128 + aud + pil;
    if (total < 16'sd0)        code = 8'h00;
    else if (total > 16'sd255) code = 8'hFF;
    else                       code = total[7:0];
  end
endmodule

// File: rtl/stereo_mpx.sv
module stereo_mpx
  import stereo_mpx_pkg::*;
#(
  parameter int AW         = 16,
  parameter int AUD_GAIN   = 109,
  parameter bit SQUARE_SUB = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [AW-1:0] left_s,
  input  logic [AW-1:0] right_s,
  input  logic          mono,
  input  logic          mute,
  input  logic          comp_ready,
  output logic          comp_valid,
  output logic [7:0]    comp_code
);
  sub_t       sub_w;
  pil_t       pil_w;
  logic [7:0] code_w;

  stereo_mpx_phase #(.SQUARE_SUB(SQUARE_SUB)) u_phase (
    .clk(clk), .rst_n(rst_n), .tick(tick), .sub_w(sub_w), .pil_w(pil_w)
  );

  stereo_mpx_mix #(.AW(AW), .AUD_GAIN(AUD_GAIN)) u_mix (
    .left_s($signed(left_s)), .right_s($signed(right_s)),
    .mono(mono), .mute(mute), .sub_w(sub_w), .pil_w(pil_w), .code(code_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      comp_code  <= 8'h80;
      comp_valid <= 1'b0;
    end else if (tick) begin
      comp_code  <= code_w;
      comp_valid <= 1'b1;
    end else if (comp_valid && comp_ready) begin
      comp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/stereo_mpx_chk.sv
module stereo_mpx_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic [AW-1:0] left_s,
  input logic [AW-1:0] right_s,
  input logic          mono,
  input logic          mute,
  input logic          comp_ready,
  input logic          comp_valid,
  input logic [7:0]    comp_code
);
  p_fill_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> comp_valid);

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (comp_valid && !comp_ready && !tick) |=> (comp_valid && $stable(comp_code)));

  p_drain_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (comp_valid && comp_ready && !tick) |=> !comp_valid);

  p_mono_mute_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && mono && mute) |=> comp_code == 8'h80);

  p_mono_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && mono && left_s == '0 && right_s == '0) |=> comp_code == 8'h80);
endmodule

bind stereo_mpx stereo_mpx_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .left_s(left_s), .right_s(right_s),
  .mono(mono), .mute(mute), .comp_ready(comp_ready),
  .comp_valid(comp_valid), .comp_code(comp_code)
);

// File: tb/stereo_mpx_bench.sv
module stereo_mpx_bench;
  localparam int AW = 16;
  localparam int SHIFT = AW - 7;
  localparam int SUB [8]  = '{0, 91, 128, 91, 0, -91, -128, -91};
  localparam int PIL [16] = '{0, 7, 13, 18, 19, 18, 13, 7,
                              0, -7, -13, -18, -19, -18, -13, -7};
  localparam int NV = 16;
  localparam int VL [NV] = '{16384, -16384, 32767, -32768, 1000, 0, 20000, -5000,
                             12345, 32767, -32768, 8000, 0, 30000, -30000, 4096};
  localparam int VR [NV] = '{0, 16384, 32767, -32768, -1000, 0, -20000, 7000,
                             -123, -32768, 32767, 8000, 25000, 30000, 1000, -4096};
  localparam bit VM [NV] = '{0, 0, 0, 0, 0, 0, 0, 0, 1, 1, 0, 1, 0, 0, 1, 0};
  localparam bit VU [NV] = '{0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 1};

  logic clk = 0;
  logic rst_n = 0;
  logic tick = 0;
  logic [AW-1:0] left_s = '0, right_s = '0;
  logic mono = 0, mute = 0, comp_ready = 1;
  logic comp_valid, hot_valid;
  logic [7:0] comp_code, hot_code;

  int errors = 0, checks = 0, ph_m = 0;

  always #4 clk = ~clk;

  stereo_mpx #(.AW(AW)) u_stereo_mpx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .left_s(left_s), .right_s(right_s),
    .mono(mono), .mute(mute), .comp_ready(comp_ready),
    .comp_valid(comp_valid), .comp_code(comp_code)
  );

  stereo_mpx #(.AW(AW), .AUD_GAIN(127)) u_hot (
    .clk(clk), .rst_n(rst_n), .tick(tick), .left_s(left_s), .right_s(right_s),
    .mono(mono), .mute(mute), .comp_ready(1'b1),
    .comp_valid(hot_valid), .comp_code(hot_code)
  );

  function automatic int model(int l, int r, bit mo, bit mu, int ph, int g);
    int m, s, a, p, v;
    m = (l + r) >>> SHIFT;
    s = mo ? 0 : ((l - r) >>> SHIFT);
    a = mu ? 0 : (((m * 128) + s * SUB[ph % 8]) * g) >>> 14;
    p = mo ? 0 : PIL[ph];
    v = 128 + a + p;
    if (v < 0) v = 0;
    if (v > 255) v = 255;
    return v;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse(int l, int r, bit mo, bit mu);
    @(negedge clk);
    left_s = AW'(l); right_s = AW'(r); mono = mo; mute = mu; tick = 1;
    @(negedge clk);
    tick = 0;
  endtask

  task automatic seek(int target);
    while (ph_m != target) begin
      pulse(0, 0, 0, 0);
      ph_m = (ph_m + 1) % 16;
    end
  endtask

  initial begin
    #1600000;
    errors++; checks++;
    $display("FAIL watchdog R2: actual=hung expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 code", comp_code, 128);
    check("R1 valid", comp_valid, 0);
    rst_n = 1;
    @(negedge clk);
    check("R1 code after release", comp_code, 128);

    // R3 R5: silent stereo walks the pilot from phase 0
    for (int k = 0; k < 16; k++) begin
      pulse(0, 0, 0, 0);
      check("R3 R5 pilot walk", comp_code, 128 + PIL[k]);
      check("R2 valid", comp_valid, 1);
      ph_m = (ph_m + 1) % 16;
    end

    // R4 R6 R7 R8: vector table
    for (int i = 0; i < NV; i++) begin
      pulse(VL[i], VR[i], VM[i], VU[i]);
      check("R6 R7 R8 vector", comp_code, model(VL[i], VR[i], VM[i], VU[i], ph_m, 109));
      ph_m = (ph_m + 1) % 16;
    end

    // R4: subcarrier peak at phase 2 with pure difference signal
    seek(2);
    pulse(16384, -16384, 0, 0);
    check("R4 sub peak", comp_code, model(16384, -16384, 0, 0, 2, 109));
    ph_m = (ph_m + 1) % 16;

    // R8: mute in stereo keeps pilot; mono mute gives 0x80
    seek(4);
    pulse(30000, -20000, 0, 1);
    check("R8 stereo mute", comp_code, 147);
    ph_m = (ph_m + 1) % 16;
    pulse(30000, -20000, 1, 1);
    check("R8 mono mute", comp_code, 128);
    ph_m = (ph_m + 1) % 16;

    // R7: mono ignores difference and pilot
    pulse(16384, 0, 1, 0);
    check("R7 mono sum", comp_code, 128 + ((32 * 128 * 109) >>> 14));
    ph_m = (ph_m + 1) % 16;

    // R9: saturation on the hot-gain instance
    seek(12);
    pulse(-32768, -32768, 0, 0);
    check("R9 low clamp", hot_code, 0);
    ph_m = (ph_m + 1) % 16;
    seek(4);
    pulse(32767, 32767, 0, 0);
    check("R9 high clamp", hot_code, 255);
    ph_m = (ph_m + 1) % 16;

    // R10: back-pressure hold, drain, overwrite
    @(negedge clk);
    check("R10 drained", comp_valid, 0);
    comp_ready = 0;
    pulse(0, 0, 0, 0);
    check("R10 loaded", comp_code, 128 + PIL[ph_m]);
    ph_m = (ph_m + 1) % 16;
    repeat (3) @(negedge clk);
    check("R10 hold valid", comp_valid, 1);
    check("R10 hold code", comp_code, 128 + PIL[(ph_m + 15) % 16]);
    pulse(20000, 20000, 1, 0);
    check("R10 overwrite", comp_code, model(20000, 20000, 1, 0, ph_m, 109));
    ph_m = (ph_m + 1) % 16;
    comp_ready = 1;
    @(negedge clk);
    check("R10 accept clears", comp_valid, 0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule